// File: doc/BRIEF.md
# Setpoint Detection Comparator Unit

This block watches a stream of tagged 16-bit samples. It evaluates each sample against a bank of programmable setpoints. Each setpoint is bound to one channel number and looks only at samples carrying that tag. It keeps a single detection flag, which one of six comparison modes updates:

- above a limit
- below a limit
- equal to a value
- inside a window
- outside a window
- a hysteresis band that forces the flag high over one limit, forces it low under the other, and holds it in between.

All flags are gathered into one status word, with setpoint n at bit n.

When a flag changes, the unit queues an update request for a downstream port or timer. A rising flag selects that setpoint's "true" value. A falling flag selects its "false" value. Requests raised in the same cycle are issued one per cycle, lowest setpoint index first.

An acquisition-start pulse clears every flag, which also clears the hysteresis memory, and drops any queued requests.

Each setpoint holds a two-state machine:

- `FLAG_LOW` moves to `FLAG_HIGH` on a transition named *assert*.
- `FLAG_HIGH` moves to `FLAG_LOW` on a transition named *deassert*.
- Either state may *hold*.
- *clear* returns a setpoint to `FLAG_LOW`.

The request sequencer has two states:

- `SEQ_IDLE` moves to `SEQ_DRAIN` on *arm*, when any flag changes.
- `SEQ_DRAIN` stays in place on *continue* while requests remain.
- `SEQ_DRAIN` returns to `SEQ_IDLE` on *empty*, or on *clear* when acquisition starts.

Top module: `sp_detect_unit`

## Requirements
- R1: After reset, `det_flags` is all zero and `upd_valid` is 0.
- R2: A setpoint evaluates a sample only when `smp_valid` is 1 and `smp_chan` equals its `cfg_chan`. Otherwise its flag keeps its value.
- R3: Mode code 0 (above) sets the flag to (sample > `cfg_lo`), compared as unsigned 16-bit, and ignores `cfg_hi`.
- R4: Mode code 1 (below) sets the flag to (sample < `cfg_hi`), compared as unsigned, and ignores `cfg_lo`.
- R5: Mode code 2 (equal) sets the flag to (sample == `cfg_lo`).
- R6: Mode code 3 (inside) sets the flag to (`cfg_lo` <= sample <= `cfg_hi`). Mode code 4 (outside) sets it to (sample < `cfg_lo` or sample > `cfg_hi`).
- R7: Mode code 5 (hysteresis) works as follows:
  - sample > `cfg_hi` sets the flag to 1.
  - sample < `cfg_lo` sets it to 0.
  - Any other sample leaves it unchanged.
- R8: Mode codes 6 and 7 (off) force the flag to 0 on every matching sample.
- R9: The flag of setpoint n sits at bit n of `det_flags` (for example, setpoints 0, 1 and 4 true give 19). It changes at the first clock edge that captures the valid sample, and at no other edge except an acquisition start.
- R10: A flag change produces a one-cycle `upd_valid` pulse one clock after the flag changes. The pulse carries `upd_idx` = n. A rise carries `upd_value` = `cfg_val_true[n]`; a fall carries `cfg_val_false[n]`.
- R11: Changes raised in the same cycle are issued on consecutive cycles, in ascending setpoint index.
- R12: `acq_start` clears all flags (and so the hysteresis memory) and all queued requests at the next edge, and produces no request. It takes priority over a sample in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | Acquisition start: clears flags and queued requests |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CHW | Channel tag of the sample |
| smp_data | input | DW | Unsigned sample value |
| cfg_mode | input | N_SP x 3 | Comparison mode code per setpoint |
| cfg_chan | input | N_SP x CHW | Channel bound to each setpoint |
| cfg_lo | input | N_SP x DW | Lower limit / compare value |
| cfg_hi | input | N_SP x DW | Upper limit |
| cfg_val_true | input | N_SP x OUTW | Value issued when a flag rises |
| cfg_val_false | input | N_SP x OUTW | Value issued when a flag falls |
| det_flags | output | N_SP | Packed detection status word |
| upd_valid | output | 1 | Update request pulse |
| upd_value | output | OUTW | Value for the update |
| upd_idx | output | log2(N_SP) | Setpoint that raised the update |

## Verification
The bench probes the exact boundaries of every mode:
- A sample equal to the limit in above or below mode. A design using >= or <= would flip the flag there.
- Both window edges. An exclusive compare would drop them.
- 0xFFFF in above mode. A signed compare would report it as false.

In hysteresis mode, samples exactly at either limit and between the limits must hold the flag. A design that re-evaluates there, or clears the memory, would lose the state.

Two setpoints rising together must come out on separate cycles in index order. A design that merges or reorders them would show the wrong `upd_idx`.

An acquisition start landing while requests are queued must leave `upd_valid` low. It must also leave the hysteresis state cleared, so a later in-band sample reads false.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [2:0] {
        SPM_ABOVE   = 3'd0,
        SPM_BELOW   = 3'd1,
        SPM_EQUAL   = 3'd2,
        SPM_INSIDE  = 3'd3,
        SPM_OUTSIDE = 3'd4,
        SPM_HYST    = 3'd5,
        SPM_OFF_A   = 3'd6,
        SPM_OFF_B   = 3'd7
    } sp_mode_e;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_DRAIN = 1'b1
    } seq_state_e;

endpackage

// File: rtl/sp_slot.sv
module sp_slot
    import sp_pkg::*;
#(
    parameter int DW  = 16,
    parameter int CHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           smp_valid,
    input  logic [CHW-1:0] smp_chan,
    input  logic [DW-1:0]  smp_data,
    input  logic [2:0]     cfg_mode,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [DW-1:0]  cfg_lo,
    input  logic [DW-1:0]  cfg_hi,
    output logic           flag_o,
    output logic           rise_o,
    output logic           fall_o
);

    flag_state_e state, state_nx;
    logic        hit;
    logic        gt_lo, lt_lo, lt_hi, gt_hi, eq_lo;
    logic        verdict;

    assign hit   = smp_valid && (smp_chan == cfg_chan) && !clear;
    assign gt_lo = smp_data > cfg_lo;
    assign lt_lo = smp_data < cfg_lo;
    assign lt_hi = smp_data < cfg_hi;
    assign gt_hi = smp_data > cfg_hi;
    assign eq_lo = smp_data == cfg_lo;

    // memoryless verdict for the non-hysteresis modes
    always_comb begin
        verdict = 1'b0;
        unique case (sp_mode_e'(cfg_mode))
            SPM_ABOVE:   verdict = gt_lo;
            SPM_BELOW:   verdict = lt_hi;
            SPM_EQUAL:   verdict = eq_lo;
            SPM_INSIDE:  verdict = !lt_lo && !gt_hi;
            SPM_OUTSIDE: verdict = lt_lo || gt_hi;
            SPM_HYST:    verdict = 1'b0;
            SPM_OFF_A:   verdict = 1'b0;
            SPM_OFF_B:   verdict = 1'b0;
        endcase
    end

    // next-state: assert / deassert / hold
    always_comb begin
        state_nx = state;
        if (hit) begin
            if (sp_mode_e'(cfg_mode) == SPM_HYST) begin
                unique case (state)
                    FLAG_LOW:  if (gt_hi) state_nx = FLAG_HIGH;
                    FLAG_HIGH: if (lt_lo) state_nx = FLAG_LOW;
                endcase
            end else begin
                state_nx = verdict ? FLAG_HIGH : FLAG_LOW;
            end
        end
    end

    // state register; clear returns to FLAG_LOW
    always_ff @(posedge clk) begin
        if (!rst_n || clear) state <= FLAG_LOW;
        else                 state <= state_nx;
    end

    // outputs
    always_comb begin
        flag_o = (state == FLAG_HIGH);
        rise_o = (state == FLAG_LOW)  && (state_nx == FLAG_HIGH);
        fall_o = (state == FLAG_HIGH) && (state_nx == FLAG_LOW);
    end

endmodule

// File: rtl/sp_update_seq.sv
module sp_update_seq
    import sp_pkg::*;
#(
    parameter int N_SP = 8,
    parameter int OUTW = 16,
    localparam int IDXW = (N_SP > 1) ? $clog2(N_SP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic [N_SP-1:0]           rise,
    input  logic [N_SP-1:0]           fall,
    input  logic [N_SP-1:0][OUTW-1:0] val_true,
    input  logic [N_SP-1:0][OUTW-1:0] val_false,
    output logic                      upd_valid,
    output logic [OUTW-1:0]           upd_value,
    output logic [IDXW-1:0]           upd_idx
);

    seq_state_e      state, state_nx;
    logic [N_SP-1:0] pend, pend_nx;
    logic [N_SP-1:0] pol, pol_nx;
    logic [IDXW-1:0] sel_idx;
    logic            sel_any;
    logic            emit;

    // lowest pending index wins
    always_comb begin
        sel_idx = '0;
        sel_any = 1'b0;
        for (int i = N_SP - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel_idx = IDXW'(i);
                sel_any = 1'b1;
            end
        end
    end

    assign emit = (state == SEQ_DRAIN) && sel_any;

    always_comb begin
        pend_nx = pend;
        pol_nx  = pol;
        if (emit) pend_nx[sel_idx] = 1'b0;
        for (int i = 0; i < N_SP; i++) begin
            if (rise[i] || fall[i]) begin
                pend_nx[i] = 1'b1;
                pol_nx[i]  = rise[i];
            end
        end
    end

    // transitions: arm / continue / empty
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (|(rise | fall)) state_nx = SEQ_DRAIN;
            SEQ_DRAIN: state_nx = (|pend_nx) ? SEQ_DRAIN : SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state <= SEQ_IDLE;
            pend  <= '0;
            pol   <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
            pol   <= pol_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            upd_valid <= 1'b0;
            upd_value <= '0;
            upd_idx   <= '0;
        end else begin
            upd_valid <= emit;
            if (emit) begin
                upd_idx   <= sel_idx;
                upd_value <= pol[sel_idx] ? val_true[sel_idx] : val_false[sel_idx];
            end
        end
    end

endmodule

// File: rtl/sp_detect_unit.sv
module sp_detect_unit
    import sp_pkg::*;
#(
    parameter int N_SP = 8,
    parameter int DW   = 16,
    parameter int CHW  = 4,
    parameter int OUTW = 16,
    localparam int IDXW = (N_SP > 1) ? $clog2(N_SP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acq_start,
    input  logic                      smp_valid,
    input  logic [CHW-1:0]            smp_chan,
    input  logic [DW-1:0]             smp_data,
    input  logic [N_SP-1:0][2:0]      cfg_mode,
    input  logic [N_SP-1:0][CHW-1:0]  cfg_chan,
    input  logic [N_SP-1:0][DW-1:0]   cfg_lo,
    input  logic [N_SP-1:0][DW-1:0]   cfg_hi,
    input  logic [N_SP-1:0][OUTW-1:0] cfg_val_true,
    input  logic [N_SP-1:0][OUTW-1:0] cfg_val_false,
    output logic [N_SP-1:0]           det_flags,
    output logic                      upd_valid,
    output logic [OUTW-1:0]           upd_value,
    output logic [IDXW-1:0]           upd_idx
);

    logic [N_SP-1:0] rise, fall;

    for (genvar g = 0; g < N_SP; g++) begin : g_slot
        sp_slot #(
            .DW  (DW),
            .CHW (CHW)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (acq_start),
            .smp_valid (smp_valid),
            .smp_chan  (smp_chan),
            .smp_data  (smp_data),
            .cfg_mode  (cfg_mode[g]),
            .cfg_chan  (cfg_chan[g]),
            .cfg_lo    (cfg_lo[g]),
            .cfg_hi    (cfg_hi[g]),
            .flag_o    (det_flags[g]),
            .rise_o    (rise[g]),
            .fall_o    (fall[g])
        );
    end

    sp_update_seq #(
        .N_SP (N_SP),
        .OUTW (OUTW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acq_start),
        .rise      (rise),
        .fall      (fall),
        .val_true  (cfg_val_true),
        .val_false (cfg_val_false),
        .upd_valid (upd_valid),
        .upd_value (upd_value),
        .upd_idx   (upd_idx)
    );

endmodule

// File: rtl/sp_detect_chk.sv
module sp_detect_chk #(
    parameter int N_SP = 8,
    parameter int DW   = 16,
    parameter int CHW  = 4,
    parameter int OUTW = 16,
    localparam int IDXW = (N_SP > 1) ? $clog2(N_SP) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acq_start,
    input logic                      smp_valid,
    input logic [CHW-1:0]            smp_chan,
    input logic [DW-1:0]             smp_data,
    input logic [N_SP-1:0][2:0]      cfg_mode,
    input logic [N_SP-1:0][CHW-1:0]  cfg_chan,
    input logic [N_SP-1:0][DW-1:0]   cfg_lo,
    input logic [N_SP-1:0][DW-1:0]   cfg_hi,
    input logic [N_SP-1:0][OUTW-1:0] cfg_val_true,
    input logic [N_SP-1:0][OUTW-1:0] cfg_val_false,
    input logic [N_SP-1:0]           det_flags,
    input logic                      upd_valid,
    input logic [OUTW-1:0]           upd_value,
    input logic [IDXW-1:0]           upd_idx
);

    // R9
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(smp_valid) && !$past(acq_start)) |-> $stable(det_flags));

    // R12
    acq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> (det_flags == '0 && !upd_valid));

    // R10
    upd_value_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_value == cfg_val_true[upd_idx] ||
                       upd_value == cfg_val_false[upd_idx]));

    for (genvar i = 0; i < N_SP; i++) begin : g_sp
        // R3
        above_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(smp_valid) && !$past(acq_start) &&
             $past(smp_chan) == $past(cfg_chan[i]) && $past(cfg_mode[i]) == 3'd0)
            |-> (det_flags[i] == ($past(smp_data) > $past(cfg_lo[i]))));

        // R7
        hyst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(smp_valid) && !$past(acq_start) &&
             $past(smp_chan) == $past(cfg_chan[i]) && $past(cfg_mode[i]) == 3'd5 &&
             $past(smp_data) > $past(cfg_hi[i]))
            |-> det_flags[i]);

        // R8
        off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(smp_valid) && $past(smp_chan) == $past(cfg_chan[i]) &&
             $past(cfg_mode[i]) >= 3'd6)
            |-> !det_flags[i]);
    end

endmodule

bind sp_detect_unit sp_detect_chk #(
    .N_SP (N_SP),
    .DW   (DW),
    .CHW  (CHW),
    .OUTW (OUTW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acq_start     (acq_start),
    .smp_valid     (smp_valid),
    .smp_chan      (smp_chan),
    .smp_data      (smp_data),
    .cfg_mode      (cfg_mode),
    .cfg_chan      (cfg_chan),
    .cfg_lo        (cfg_lo),
    .cfg_hi        (cfg_hi),
    .cfg_val_true  (cfg_val_true),
    .cfg_val_false (cfg_val_false),
    .det_flags     (det_flags),
    .upd_valid     (upd_valid),
    .upd_value     (upd_value),
    .upd_idx       (upd_idx)
);

// File: tb/sp_detect_unit_bench.sv
`timescale 1ns/1ps
module sp_detect_unit_bench;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_start = 1'b0;
    logic smp_valid = 1'b0;
    logic [3:0]  smp_chan = '0;
    logic [15:0] smp_data = '0;
    logic [N-1:0][2:0]  cfg_mode;
    logic [N-1:0][3:0]  cfg_chan;
    logic [N-1:0][15:0] cfg_lo, cfg_hi, cfg_vt, cfg_vf;
    logic [N-1:0] det_flags;
    logic         upd_valid;
    logic [15:0]  upd_value;
    logic [2:0]   upd_idx;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sp_detect_unit u_sp_detect_unit (
        .clk (clk), .rst_n (rst_n), .acq_start (acq_start),
        .smp_valid (smp_valid), .smp_chan (smp_chan), .smp_data (smp_data),
        .cfg_mode (cfg_mode), .cfg_chan (cfg_chan), .cfg_lo (cfg_lo), .cfg_hi (cfg_hi),
        .cfg_val_true (cfg_vt), .cfg_val_false (cfg_vf),
        .det_flags (det_flags), .upd_valid (upd_valid),
        .upd_value (upd_value), .upd_idx (upd_idx)
    );

    task automatic chk_flags(string req, logic [N-1:0] exp);
        checks++;
        if (det_flags !== exp) begin
            fails++;
            $display("FAIL %s flags actual=%h expected=%h", req, det_flags, exp);
        end
    endtask

    task automatic chk_upd(string req, logic ev, logic [2:0] eidx, logic [15:0] eval);
        checks++;
        if (upd_valid !== ev || (ev && (upd_idx !== eidx || upd_value !== eval))) begin
            fails++;
            $display("FAIL %s upd actual=%b/%0d/%h expected=%b/%0d/%h",
                     req, upd_valid, upd_idx, upd_value, ev, eidx, eval);
        end
    endtask

    // present one sample; returns at the negedge after the capturing edge
    task automatic send(logic [3:0] ch, logic [15:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_acq();
        @(negedge clk);
        acq_start = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
    endtask

    task automatic t_reset();
        chk_flags("R1", '0);
        chk_upd("R1", 1'b0, 3'd0, 16'h0);
    endtask

    task automatic t_above();
        cfg_mode[0] = 3'd0; cfg_chan[0] = 4'd1; cfg_lo[0] = 16'd100; cfg_hi[0] = 16'd5;
        send(4'd1, 16'd101);  chk_flags("R3", 8'h01);
        send(4'd1, 16'd100);  chk_flags("R3", 8'h00);
        send(4'd1, 16'hFFFF); chk_flags("R3", 8'h01);
        settle();
    endtask

    task automatic t_below();
        cfg_mode[1] = 3'd1; cfg_chan[1] = 4'd2; cfg_lo[1] = 16'd9999; cfg_hi[1] = 16'd50;
        send(4'd2, 16'd49); chk_flags("R4", 8'h03);
        send(4'd2, 16'd50); chk_flags("R4", 8'h01);
        settle();
    endtask

    task automatic t_equal();
        cfg_mode[2] = 3'd2; cfg_chan[2] = 4'd3; cfg_lo[2] = 16'h1234;
        send(4'd3, 16'h1234); chk_flags("R5", 8'h05);
        send(4'd3, 16'h1235); chk_flags("R5", 8'h01);
        settle();
    endtask

    task automatic t_window();
        cfg_mode[3] = 3'd3; cfg_chan[3] = 4'd4; cfg_lo[3] = 16'd10; cfg_hi[3] = 16'd20;
        cfg_mode[4] = 3'd4; cfg_chan[4] = 4'd4; cfg_lo[4] = 16'd10; cfg_hi[4] = 16'd20;
        send(4'd4, 16'd10); chk_flags("R6", 8'h09);
        send(4'd4, 16'd21); chk_flags("R6", 8'h11);
        send(4'd4, 16'd9);  chk_flags("R6", 8'h11);
        send(4'd4, 16'd20); chk_flags("R6", 8'h09);
        settle();
    endtask

    task automatic t_hyst();
        cfg_mode[5] = 3'd5; cfg_chan[5] = 4'd5; cfg_lo[5] = 16'd100; cfg_hi[5] = 16'd200;
        send(4'd5, 16'd150); chk_flags("R7", 8'h09);
        send(4'd5, 16'd201); chk_flags("R7", 8'h29);
        send(4'd5, 16'd150); chk_flags("R7", 8'h29);
        send(4'd5, 16'd100); chk_flags("R7", 8'h29);
        send(4'd5, 16'd99);  chk_flags("R7", 8'h09);
        send(4'd5, 16'd200); chk_flags("R7", 8'h09);
        settle();
    endtask

    task automatic t_tag();
        send(4'd6, 16'd250); chk_flags("R2", 8'h09);
        send(4'd0, 16'd500); chk_flags("R2", 8'h09);
        settle();
    endtask

    task automatic t_off();
        cfg_mode[6] = 3'd0; cfg_chan[6] = 4'd7; cfg_lo[6] = 16'd0;
        send(4'd7, 16'd5); chk_flags("R8", 8'h49);
        cfg_mode[6] = 3'd6;
        send(4'd7, 16'd5); chk_flags("R8", 8'h09);
        cfg_mode[6] = 3'd0;
        send(4'd7, 16'd5); chk_flags("R8", 8'h49);
        cfg_mode[6] = 3'd7;
        send(4'd7, 16'd5); chk_flags("R8", 8'h09);
        settle();
    endtask

    task automatic t_status();
        pulse_acq(); chk_flags("R12", 8'h00);
        settle();
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'd1; smp_data = 16'd101;
        chk_flags("R9", 8'h00);               // not yet captured
        @(negedge clk);
        smp_valid = 1'b0;
        chk_flags("R9", 8'h01);
        send(4'd2, 16'd1);  chk_flags("R9", 8'h03);
        send(4'd4, 16'd30); chk_flags("R9", 8'd19);
        settle();
    endtask

    task automatic t_update();
        pulse_acq(); settle();
        send(4'd1, 16'd101);
        chk_flags("R10", 8'h01); chk_upd("R10", 1'b0, 3'd0, 16'h0);
        @(negedge clk); chk_upd("R10", 1'b1, 3'd0, 16'h1000);
        @(negedge clk); chk_upd("R10", 1'b0, 3'd0, 16'h0);
        send(4'd1, 16'd5);
        @(negedge clk); chk_upd("R10", 1'b1, 3'd0, 16'h2000);
        @(negedge clk); chk_upd("R10", 1'b0, 3'd0, 16'h0);
        settle();
    endtask

    task automatic t_multi();
        pulse_acq(); settle();
        cfg_mode[2] = 3'd2; cfg_chan[2] = 4'd9; cfg_lo[2] = 16'd7;
        cfg_mode[5] = 3'd5; cfg_chan[5] = 4'd9; cfg_lo[5] = 16'd1; cfg_hi[5] = 16'd6;
        send(4'd9, 16'd7); chk_flags("R11", 8'h24);
        @(negedge clk); chk_upd("R11", 1'b1, 3'd2, 16'h1002);
        @(negedge clk); chk_upd("R11", 1'b1, 3'd5, 16'h1005);
        @(negedge clk); chk_upd("R11", 1'b0, 3'd0, 16'h0);
        settle();
    endtask

    task automatic t_acq();
        pulse_acq();
        chk_flags("R12", 8'h00); chk_upd("R12", 1'b0, 3'd0, 16'h0);
        @(negedge clk); chk_upd("R12", 1'b0, 3'd0, 16'h0);
        send(4'd9, 16'd3); chk_flags("R12", 8'h00);
        send(4'd9, 16'd7); chk_flags("R12", 8'h24);
        acq_start = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
        chk_flags("R12", 8'h00); chk_upd("R12", 1'b0, 3'd0, 16'h0);
        @(negedge clk); chk_upd("R12", 1'b0, 3'd0, 16'h0);
        settle();
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_mode[i] = 3'd7; cfg_chan[i] = 4'd0;
            cfg_lo[i] = '0; cfg_hi[i] = '0;
            cfg_vt[i] = 16'h1000 + 16'(i);
            cfg_vf[i] = 16'h2000 + 16'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_above();
        t_below();
        t_equal();
        t_window();
        t_hyst();
        t_tag();
        t_off();
        t_status();
        t_update();
        t_multi();
        t_acq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule